// File: doc/BRIEF.md
# Masked Pattern Detector with Automatic Clear

This block owns the output register of a wide accumulator and watches the value being loaded into it. Each time the register loads, the block compares the incoming value against a pattern. Bit positions that are set in a mask are left out of the comparison. Two flags are registered together with the data.

- The match flag is high when every compared bit equals the pattern.
- The inverse-match flag is high when every compared bit equals the inverted pattern.

The flags therefore describe the value that the output register holds in the same cycle.

Overflow and underflow come from the history of the two flags. Take a pattern of zero and a mask whose low N bits are ones. The match flag then means "the value fits above bit N as a positive number", and the inverse-match flag means "the value fits as a negative number". Leaving either state is reported as overflow or underflow. The pattern can be a constant parameter or the C input. The mask can be a constant, the C input, or the inverted C shifted left by one or two places, which suits rounding schemes.

An optional automatic clear zeroes the register one cycle after a match. The clear has one of two priorities with respect to the register's clock enable: it either overrides the enable or waits for it.

Top module: `masked_match_unit`

## Requirements
- R1: After an edge at which the register loads, `match` is 1 exactly when `((p_d ^ pat) & ~msk) == 0` for the `p_d`, pattern `pat` and mask `msk` of that edge; a mask bit of 1 means the bit is ignored.
- R2: Under the same conditions, `match_inv` is 1 exactly when `((p_d ^ ~pat) & ~msk) == 0`.
- R3: With `PAT_SRC`=0 the pattern is the parameter `PATTERN`; with `PAT_SRC`=1 it is `c_in`.
- R4: With `MASK_SRC`=0 the mask is the parameter `MASK`; with `MASK_SRC`=1 it is `c_in`.
- R5: With `MASK_SRC`=2 the mask is `(~c_in) << 1`, and with `MASK_SRC`=3 it is `(~c_in) << 2`, with zeros shifted in at the bottom so that those low bits are always compared.
- R6: `ovf` is 1 while the most recent load cleared `match` and the load before it had set `match`.
- R7: `unf` is 1 while the most recent load cleared `match_inv` and the load before it had set `match_inv`.
- R8: With `AUTO_CLR`=1 and `CLR_PRIO`=0, if `match` is 1 then the next edge clears `p_q`, both flags and the flag history, whatever the value of `ce_p`.
- R9: With `AUTO_CLR`=1 and `CLR_PRIO`=1, a pending clear (`match` is 1) takes effect only at an edge where `ce_p` is 1. Until then `p_q` and the flags hold, and the value on `p_d` is not loaded.
- R10: With `ce_p`=0 and no clear, `p_q`, `match`, `match_inv`, `ovf` and `unf` all hold.
- R11: A synchronous `rst` of 1 clears `p_q`, both flags, `ovf` and `unf` at the next edge.
- R12: With `ce_p`=1 and no clear, `p_q` takes `p_d` at the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_p | input | 1 | Clock enable of the output register |
| p_d | input | W | Accumulator result presented to the register |
| c_in | input | W | C operand, used as pattern or mask source |
| p_q | output | W | Registered accumulator value |
| match | output | 1 | Masked equality with the pattern |
| match_inv | output | 1 | Masked equality with the inverted pattern |
| ovf | output | 1 | Match flag fell at the last load |
| unf | output | 1 | Inverse-match flag fell at the last load |

## Verification
The assertions assume that `c_in` is valid in every cycle in which `ce_p` is high, because the C input feeds the comparison directly at the loading edge. They also assume that `rst` is held for at least one edge before the first check. The stimulus changes `c_in` and `p_d` only on falling edges and begins with reset asserted. Configurations that take their pattern or mask from C are fed C values that are well defined in every cycle.

// File: rtl/masked_match_unit.sv
module masked_match_unit #(
  parameter int W = 58,
  parameter int PAT_SRC = 0,
  parameter int MASK_SRC = 0,
  parameter logic [W-1:0] PATTERN = '0,
  parameter logic [W-1:0] MASK = {{(W-8){1'b0}}, 8'hFF},
  parameter int AUTO_CLR = 0,
  parameter int CLR_PRIO = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce_p,
  input  logic [W-1:0] p_d,
  input  logic [W-1:0] c_in,
  output logic [W-1:0] p_q,
  output logic         match,
  output logic         match_inv,
  output logic         ovf,
  output logic         unf
);
  logic [W-1:0] pat, msk;
  logic hist_m, hist_b, clr, load, hit, hit_inv;

  generate
    if (PAT_SRC == 1) begin : g_pat_c
      assign pat = c_in;
    end else begin : g_pat_k
      assign pat = PATTERN;
    end

    if (MASK_SRC == 1) begin : g_msk_c
      assign msk = c_in;
    end else if (MASK_SRC == 2) begin : g_msk_r1
      assign msk = {~c_in[W-2:0], 1'b0};
    end else if (MASK_SRC == 3) begin : g_msk_r2
      assign msk = {~c_in[W-3:0], 2'b00};
    end else begin : g_msk_k
      assign msk = MASK;
    end

    if (AUTO_CLR == 0) begin : g_noclr
      assign clr = rst;
    end else if (CLR_PRIO == 0) begin : g_clr_rst
      assign clr = rst | match;
    end else begin : g_clr_ce
      assign clr = rst | (match & ce_p);
    end
  endgenerate

  assign hit     = ((p_d ^ pat) & ~msk) == '0;
  assign hit_inv = ((p_d ^ ~pat) & ~msk) == '0;
  assign load    = ce_p & ~clr;

  always_ff @(posedge clk) begin
    if (clr) begin
      p_q       <= '0;
      match     <= 1'b0;
      match_inv <= 1'b0;
      hist_m    <= 1'b0;
      hist_b    <= 1'b0;
    end else if (load) begin
      p_q       <= p_d;
      match     <= hit;
      match_inv <= hit_inv;
      hist_m    <= match;
      hist_b    <= match_inv;
    end
  end

  assign ovf = hist_m & ~match;
  assign unf = hist_b & ~match_inv;
endmodule

// File: rtl/masked_match_unit_chk.sv
module masked_match_unit_chk #(
  parameter int W = 58,
  parameter int PAT_SRC = 0,
  parameter int MASK_SRC = 0,
  parameter logic [W-1:0] PATTERN = '0,
  parameter logic [W-1:0] MASK = '0,
  parameter int AUTO_CLR = 0,
  parameter int CLR_PRIO = 0
) (
  input logic         clk,
  input logic         rst,
  input logic         ce_p,
  input logic [W-1:0] p_d,
  input logic [W-1:0] c_in,
  input logic [W-1:0] p_q,
  input logic         match,
  input logic         match_inv,
  input logic         ovf,
  input logic         unf
);
  logic [W-1:0] rp, rm;
  logic pend, will_load, ref_m, ref_b;

  always_comb begin
    rp = (PAT_SRC == 1) ? c_in : PATTERN;
    case (MASK_SRC)
      1:       rm = c_in;
      2:       rm = (~c_in) << 1;
      3:       rm = (~c_in) << 2;
      default: rm = MASK;
    endcase
  end

  assign ref_m     = ((p_d & ~rm) == (rp & ~rm));
  assign ref_b     = ((p_d & ~rm) == (~rp & ~rm));
  assign pend      = (AUTO_CLR != 0) && match && ((CLR_PRIO == 0) || ce_p);
  assign will_load = ce_p && !pend;

  AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (rst)
    will_load |=> (match == $past(ref_m))); // R1
  AST_INV_FLAG: assert property (@(posedge clk) disable iff (rst)
    will_load |=> (match_inv == $past(ref_b))); // R2
  AST_OVF_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> $fell(match)); // R6
  AST_UNF_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    $rose(unf) |-> $fell(match_inv)); // R7
  AST_AUTOCLEAR: assert property (@(posedge clk) disable iff (rst)
    pend |=> (p_q == '0 && !match && !match_inv)); // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ce_p && !pend) |=> ($stable(p_q) && $stable(match) && $stable(ovf))); // R10
  AST_LOAD: assert property (@(posedge clk) disable iff (rst)
    will_load |=> (p_q == $past(p_d))); // R12
  AST_RESET: assert property (@(posedge clk)
    rst |=> (p_q == '0 && !match && !match_inv && !ovf && !unf)); // R11
endmodule

bind masked_match_unit masked_match_unit_chk #(
  .W(W), .PAT_SRC(PAT_SRC), .MASK_SRC(MASK_SRC), .PATTERN(PATTERN),
  .MASK(MASK), .AUTO_CLR(AUTO_CLR), .CLR_PRIO(CLR_PRIO)
) u_chk (
  .clk(clk), .rst(rst), .ce_p(ce_p), .p_d(p_d), .c_in(c_in), .p_q(p_q),
  .match(match), .match_inv(match_inv), .ovf(ovf), .unf(unf)
);

// File: tb/tb_masked_match_unit.sv
module tb_masked_match_unit;
  localparam int W = 58;
  localparam int NC = 6;
  // configs: 0 overflow watch, 1 auto-clear reset prio, 2 auto-clear CE prio,
  //          3 rounding mask 1, 4 pattern and mask from C, 5 rounding mask 2
  localparam int CPS[NC] = '{0, 0, 0, 0, 1, 0};
  localparam int CMS[NC] = '{0, 0, 0, 2, 1, 3};
  localparam logic [W-1:0] CPAT[NC] = '{58'h0, 58'h10, 58'h10, 58'h0, 58'h0, 58'h0};
  localparam logic [W-1:0] CMSK[NC] = '{58'hFF, 58'h0, 58'h0, 58'h0, 58'h0, 58'h0};
  localparam int CAR[NC] = '{0, 1, 1, 0, 0, 0};
  localparam int CPR[NC] = '{0, 0, 1, 0, 0, 0};
  localparam logic [W-1:0] C7 = ~58'd7;

  typedef struct packed { logic ce; logic [W-1:0] d; logic [W-1:0] c; } vec_t;
  localparam int NV = 19;
  localparam vec_t VT[NV] = '{
    '{1'b1, 58'h5,   C7},            // R1 cfg0 match, R12 load
    '{1'b1, 58'h80,  C7},            // R1 still inside mask
    '{1'b1, 58'h100, C7},            // R6 leaves positive range
    '{1'b1, 58'h300, C7},            // R6 ovf drops again
    '{1'b1, 58'h10,  C7},            // R3 constant pattern hit cfg1/2
    '{1'b0, 58'h20,  C7},            // R8 clear with ce low, R9 hold
    '{1'b0, 58'h20,  C7},            // R9 still pending
    '{1'b1, 58'h20,  C7},            // R9 clear at ce, not loaded
    '{1'b1, 58'd0 - 58'd1,   C7},    // R2 inverse match
    '{1'b1, 58'd0 - 58'd512, C7},    // R7 underflow
    '{1'b0, 58'h7,   C7},            // R10 hold
    '{1'b1, 58'hE,   C7},            // R5 shift-1 mask hit
    '{1'b1, 58'hF,   C7},            // R5 bit0 compared
    '{1'b1, 58'h1C,  C7},            // R5 shift-2 mask hit
    '{1'b1, 58'h1D,  C7},            // R5 bit0 compared
    '{1'b1, 58'h5,   58'hF},         // R4 mask/pattern from C
    '{1'b1, 58'h15,  58'hF},         // R4 upper bit compared
    '{1'b1, 58'h10,  58'hF},         // R8 second hit
    '{1'b1, 58'h33,  58'hF}          // R8 cleared regardless of d
  };

  typedef struct packed { logic [W-1:0] p; logic m, b, hm, hb; } st_t;

  logic clk = 1'b0, rst = 1'b1, ce = 1'b0;
  logic [W-1:0] d = '0, c = '0;
  logic [W-1:0] pq [NC];
  logic mt [NC], mb [NC], ov [NC], un [NC];
  st_t model [NC];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  for (genvar g = 0; g < NC; g++) begin : g_cfg
    masked_match_unit #(
      .W(W), .PAT_SRC(CPS[g]), .MASK_SRC(CMS[g]), .PATTERN(CPAT[g]),
      .MASK(CMSK[g]), .AUTO_CLR(CAR[g]), .CLR_PRIO(CPR[g])
    ) dut (
      .clk(clk), .rst(rst), .ce_p(ce), .p_d(d), .c_in(c), .p_q(pq[g]),
      .match(mt[g]), .match_inv(mb[g]), .ovf(ov[g]), .unf(un[g])
    );
  end

  function automatic st_t step(st_t s, int k, logic r, logic e, logic [W-1:0] dv, logic [W-1:0] cv);
    logic [W-1:0] pt, mk;
    st_t n;
    pt = (CPS[k] == 1) ? cv : CPAT[k];
    case (CMS[k])
      1: mk = cv;
      2: mk = {~cv[W-2:0], 1'b0};
      3: mk = {~cv[W-3:0], 2'b00};
      default: mk = CMSK[k];
    endcase
    if (r || (CAR[k] != 0 && s.m && (CPR[k] == 0 || e))) n = '0;
    else if (e) begin
      n.p = dv;
      n.m = (dv & ~mk) == (pt & ~mk);
      n.b = (dv & ~mk) == (~pt & ~mk);
      n.hm = s.m;
      n.hb = s.b;
    end else n = s;
    return n;
  endfunction

  task automatic cmp(int k, string tag);
    logic eo, eu;
    eo = model[k].hm & ~model[k].m;
    eu = model[k].hb & ~model[k].b;
    checks++;
    if (pq[k] !== model[k].p) begin fails++; $display("FAIL %s R12 cfg%0d p_q %h exp %h", tag, k, pq[k], model[k].p); end
    else if (mt[k] !== model[k].m) begin fails++; $display("FAIL %s R1 cfg%0d match %b exp %b", tag, k, mt[k], model[k].m); end
    else if (mb[k] !== model[k].b) begin fails++; $display("FAIL %s R2 cfg%0d match_inv %b exp %b", tag, k, mb[k], model[k].b); end
    else if (ov[k] !== eo) begin fails++; $display("FAIL %s R6 cfg%0d ovf %b exp %b", tag, k, ov[k], eo); end
    else if (un[k] !== eu) begin fails++; $display("FAIL %s R7 cfg%0d unf %b exp %b", tag, k, un[k], eu); end
  endtask

  task automatic apply(logic r, logic e, logic [W-1:0] dv, logic [W-1:0] cv, string tag);
    @(negedge clk);
    rst = r; ce = e; d = dv; c = cv;
    for (int k = 0; k < NC; k++) model[k] = step(model[k], k, r, e, dv, cv);
    @(posedge clk);
    #1;
    for (int k = 0; k < NC; k++) cmp(k, tag);
  endtask

  initial begin
    for (int k = 0; k < NC; k++) model[k] = '0;
    apply(1'b1, 1'b1, 58'h10, C7, "reset");
    for (int k = 0; k < NC; k++) begin  // R11 reset state checked directly
      checks++;
      if (pq[k] !== '0 || mt[k] || mb[k] || ov[k] || un[k]) begin
        fails++; $display("FAIL R11 cfg%0d p_q %h flags %b%b%b%b exp 0", k, pq[k], mt[k], mb[k], ov[k], un[k]);
      end
    end
    for (int i = 0; i < NV; i++) apply(1'b0, VT[i].ce, VT[i].d, VT[i].c, $sformatf("vec%0d", i));
    // directed: build ovf on cfg0 then hold with ce low (R10)
    apply(1'b0, 1'b1, 58'h1, C7, "r10_pre");
    apply(1'b0, 1'b1, 58'h400, C7, "r10_ovf");
    apply(1'b0, 1'b0, 58'h2, C7, "r10_hold");
    checks++;
    if (ov[0] !== 1'b1 || pq[0] !== 58'h400) begin
      fails++; $display("FAIL R10 ovf %b p_q %h exp 1 400", ov[0], pq[0]);
    end
    // directed: reset in mid-run with ce high and a matching value (R11)
    apply(1'b1, 1'b1, 58'h10, C7, "r11_mid");
    checks++;
    if (pq[0] !== '0 || ov[0] !== 1'b0 || mt[1] !== 1'b0) begin
      fails++; $display("FAIL R11 p_q %h ovf %b match %b exp 0 0 0", pq[0], ov[0], mt[1]);
    end
    apply(1'b0, 1'b1, 58'hFF, C7, "after_reset");
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R12 finished %b exp 1", done);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule